// File: doc/BRIEF.md
# Debug Register Access Bridge

This block is the system-clock side of a debug transport. A scan controller, outside this block, shifts a 41-bit access word. On the update event for that word, the bridge turns it into one request on a valid/ready register bus towards a debug module. It then waits for the single-cycle response and keeps the read result. It also keeps a two-bit status, so that the next capture of the access word returns the last address, the last read data and the outcome.

A 32-bit control word sits beside the access word. It reports fixed facts about the bridge together with the sticky status. Through this word, software can clear the sticky status and hold the debug module in reset through a low-active reset output.

Back-pressure rules: the bridge holds an accepted request until the ready input is high, and raises request valid for exactly one cycle in which ready is high. It raises response ready only while it waits for a response. A response valid pulse that arrives while response ready is low is ignored. All event inputs are single-cycle pulses that are already in the system clock domain.

Top module: `dmi_bridge`

## Requirements
- R1: After reset, request valid and response ready are low, the reset output is high (released), and the capture word reads all zeros.
- R2: The access word is laid out as address in bits [40:34], data in bits [33:2] and op in bits [1:0]. Op 01 requests a read and op 10 requests a write. Ops 00 and 11 start no request and leave the status at 00.
- R3: An accepted update raises request valid for exactly one cycle. During that cycle the request carries the scanned address and data, with the write flag high for op 10 and low for op 01.
- R4: Request valid is only high while ready is high. A request that meets ready low stays pending and is issued in the first cycle in which ready is high.
- R5: Response ready is high from the cycle after the request handshake until a response valid pulse is taken, and low otherwise. A read response without error stores its data into capture bits [33:2]. A write response leaves those bits unchanged.
- R6: The capture op field reads 00 when the bridge is idle with a clear status. It reads 11 while a request is pending or in flight. A capture event during that time makes status 11 sticky.
- R7: An update that arrives while a request is outstanding is ignored and sets the sticky status to 11. While the sticky status is not 00, every update is ignored.
- R8: A response with its error flag set makes the sticky status 10, which capture bits [1:0] then report. The read data field is not updated.
- R9: The control word reads version 1 in bits [3:0], the address width 7 in bits [9:4], the sticky status in bits [11:10], the idle hint 1 in bits [14:12], and zeros elsewhere: 0x00001071 while the status is clear.
- R10: A control update with bit 16 set clears the sticky status to 00.
- R11: A control update writes bit 17 to the reset output, where 1 drives it low and 0 releases it. While the output is low, no request or response handshake takes place, any outstanding access is dropped, and updates are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dmi_upd_i | input | 1 | Update pulse for the access word |
| dmi_cap_i | input | 1 | Capture pulse for the access word |
| dmi_scan_i | input | 41 | Shifted access word, valid with the update pulse |
| dmi_capture_o | output | 41 | Value to load on capture: address, data, status |
| ctl_upd_i | input | 1 | Update pulse for the control word |
| ctl_wdata_i | input | 32 | Shifted control word, valid with its update pulse |
| ctl_rdata_o | output | 32 | Control word read value |
| dm_rst_no | output | 1 | Debug module reset, active low |
| req_valid_o | output | 1 | Request valid, one cycle |
| req_ready_i | input | 1 | Debug module ready for a request |
| req_addr_o | output | 7 | Request register address |
| req_write_o | output | 1 | 1 write, 0 read |
| req_wdata_o | output | 32 | Request write data |
| rsp_valid_i | input | 1 | Response valid, one cycle |
| rsp_ready_o | output | 1 | Bridge waits for a response |
| rsp_rdata_i | input | 32 | Response read data |
| rsp_err_i | input | 1 | Response error flag |

## Verification
Request valid is a combinational function of the engine state and ready. It is due in the cycle that follows the update edge when ready is already high, so the bench samples it 1 ns after it drives ready at a falling edge. Response ready, the capture fields, the control word and the reset output change on the rising edge that samples the stimulus. The bench therefore drives inputs at a falling edge and checks these results at the next falling edge. Whenever something must be ignored, the bench watches request valid for two cycles and reads the capture address, status and data afterwards.

// File: rtl/dmib_pkg.sv
package dmib_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } eng_state_e;

  localparam logic [1:0] OP_NOP   = 2'b00;
  localparam logic [1:0] OP_READ  = 2'b01;
  localparam logic [1:0] OP_WRITE = 2'b10;

  localparam logic [1:0] STAT_OK   = 2'b00;
  localparam logic [1:0] STAT_FAIL = 2'b10;
  localparam logic [1:0] STAT_BUSY = 2'b11;

  localparam int CTL_CLR_BIT  = 16;
  localparam int CTL_HARD_BIT = 17;
  localparam int CTL_W        = 32;

endpackage

// File: rtl/dmib_engine.sv
module dmib_engine
  import dmib_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              abort_i,
  input  logic              upd_i,
  input  logic [ADDR_W+DATA_W+1:0] scan_i,
  input  logic              stick_nz_i,
  input  logic              req_ready_i,
  output logic              req_valid_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic              req_write_o,
  output logic [DATA_W-1:0] req_wdata_o,
  input  logic              rsp_valid_i,
  output logic              rsp_ready_o,
  input  logic [DATA_W-1:0] rsp_rdata_i,
  input  logic              rsp_err_i,
  output logic              busy_o,
  output logic              busy_hit_o,
  output logic              fail_hit_o,
  output logic [DATA_W-1:0] result_o
);

  localparam int OP_LSB   = 0;
  localparam int DATA_LSB = 2;
  localparam int ADDR_LSB = DATA_LSB + DATA_W;

  eng_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              wr_q;
  logic [DATA_W-1:0] result_q;

  logic [1:0]        scan_op;
  logic              op_live;
  logic              accept;
  logic              req_hs;
  logic              rsp_hs;

  assign scan_op = scan_i[OP_LSB +: 2];
  assign op_live = (scan_op == OP_READ) || (scan_op == OP_WRITE);
  assign accept  = upd_i && !abort_i && !stick_nz_i &&
                   (state_q == ST_IDLE) && op_live;

  assign req_valid_o = (state_q == ST_ISSUE) && req_ready_i && !abort_i;
  assign rsp_ready_o = (state_q == ST_WAIT) && !abort_i;
  assign req_hs      = req_valid_o;
  assign rsp_hs      = rsp_ready_o && rsp_valid_i;

  assign busy_o      = (state_q != ST_IDLE) && !abort_i;
  assign busy_hit_o  = upd_i && busy_o;
  assign fail_hit_o  = rsp_hs && rsp_err_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      wdata_q  <= '0;
      wr_q     <= 1'b0;
      result_q <= '0;
    end else if (abort_i) begin
      state_q <= ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            state_q <= ST_ISSUE;
            addr_q  <= scan_i[ADDR_LSB +: ADDR_W];
            wdata_q <= scan_i[DATA_LSB +: DATA_W];
            wr_q    <= (scan_op == OP_WRITE);
          end
        end
        ST_ISSUE: begin
          if (req_hs) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (rsp_hs) begin
            state_q <= ST_IDLE;
            if (!rsp_err_i && !wr_q) result_q <= rsp_rdata_i;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_addr_o  = addr_q;
  assign req_write_o = wr_q;
  assign req_wdata_o = wdata_q;
  assign result_o    = result_q;

endmodule

// File: rtl/dmib_sticky.sv
module dmib_sticky
  import dmib_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clear_i,
  input  logic       fail_hit_i,
  input  logic       busy_hit_i,
  output logic [1:0] sticky_o,
  output logic       nz_o
);

  logic [1:0] sticky_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sticky_q <= STAT_OK;
    end else if (clear_i) begin
      sticky_q <= STAT_OK;
    end else if (sticky_q == STAT_OK) begin
      if (fail_hit_i)      sticky_q <= STAT_FAIL;
      else if (busy_hit_i) sticky_q <= STAT_BUSY;
    end
  end

  assign sticky_o = sticky_q;
  assign nz_o     = (sticky_q != STAT_OK);

endmodule

// File: rtl/dmib_ctl.sv
module dmib_ctl
  import dmib_pkg::*;
#(
  parameter int VERSION   = 1,
  parameter int ABITS     = 7,
  parameter int IDLE_HINT = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic [CTL_W-1:0]  wdata_i,
  input  logic [1:0]        sticky_i,
  output logic [CTL_W-1:0]  rdata_o,
  output logic              clear_o,
  output logic              dm_rst_no
);

  logic hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hold_q <= 1'b0;
    else if (upd_i) hold_q <= wdata_i[CTL_HARD_BIT];
  end

  assign clear_o   = upd_i && wdata_i[CTL_CLR_BIT];
  assign dm_rst_no = !hold_q;

  always_comb begin
    rdata_o        = '0;
    rdata_o[3:0]   = 4'(VERSION);
    rdata_o[9:4]   = 6'(ABITS);
    rdata_o[11:10] = sticky_i;
    rdata_o[14:12] = 3'(IDLE_HINT);
  end

endmodule

// File: rtl/dmi_bridge.sv
module dmi_bridge
  import dmib_pkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int DATA_W    = 32,
  parameter int VERSION   = 1,
  parameter int IDLE_HINT = 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     dmi_upd_i,
  input  logic                     dmi_cap_i,
  input  logic [ADDR_W+DATA_W+1:0] dmi_scan_i,
  output logic [ADDR_W+DATA_W+1:0] dmi_capture_o,
  input  logic                     ctl_upd_i,
  input  logic [31:0]              ctl_wdata_i,
  output logic [31:0]              ctl_rdata_o,
  output logic                     dm_rst_no,
  output logic                     req_valid_o,
  input  logic                     req_ready_i,
  output logic [ADDR_W-1:0]        req_addr_o,
  output logic                     req_write_o,
  output logic [DATA_W-1:0]        req_wdata_o,
  input  logic                     rsp_valid_i,
  output logic                     rsp_ready_o,
  input  logic [DATA_W-1:0]        rsp_rdata_i,
  input  logic                     rsp_err_i
);

  logic              busy;
  logic              busy_upd_hit;
  logic              fail_hit;
  logic              stick_nz;
  logic              clear;
  logic [1:0]        sticky;
  logic [1:0]        cap_status;
  logic [DATA_W-1:0] result;

  dmib_engine #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) eng_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .abort_i     (!dm_rst_no),
    .upd_i       (dmi_upd_i),
    .scan_i      (dmi_scan_i),
    .stick_nz_i  (stick_nz),
    .req_ready_i (req_ready_i),
    .req_valid_o (req_valid_o),
    .req_addr_o  (req_addr_o),
    .req_write_o (req_write_o),
    .req_wdata_o (req_wdata_o),
    .rsp_valid_i (rsp_valid_i),
    .rsp_ready_o (rsp_ready_o),
    .rsp_rdata_i (rsp_rdata_i),
    .rsp_err_i   (rsp_err_i),
    .busy_o      (busy),
    .busy_hit_o  (busy_upd_hit),
    .fail_hit_o  (fail_hit),
    .result_o    (result)
  );

  dmib_sticky stk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (clear),
    .fail_hit_i (fail_hit),
    .busy_hit_i (busy_upd_hit || (dmi_cap_i && busy)),
    .sticky_o   (sticky),
    .nz_o       (stick_nz)
  );

  dmib_ctl #(
    .VERSION  (VERSION),
    .ABITS    (ADDR_W),
    .IDLE_HINT(IDLE_HINT)
  ) ctl_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .upd_i     (ctl_upd_i),
    .wdata_i   (ctl_wdata_i),
    .sticky_i  (sticky),
    .rdata_o   (ctl_rdata_o),
    .clear_o   (clear),
    .dm_rst_no (dm_rst_no)
  );

  assign cap_status    = stick_nz ? sticky : (busy ? STAT_BUSY : STAT_OK);
  assign dmi_capture_o = {req_addr_o, result, cap_status};

endmodule

// File: rtl/dmi_bridge_chk.sv
module dmi_bridge_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_valid_o,
  input logic       req_ready_i,
  input logic       rsp_valid_i,
  input logic       rsp_ready_o,
  input logic       dm_rst_no,
  input logic       clr_req,
  input logic [1:0] sticky
);

  // R3
  req_one_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |=> !req_valid_o);

  // R4
  req_needs_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> req_ready_i);

  // R5
  rsp_taken_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_i && rsp_ready_o) |=> !rsp_ready_o);

  // R5
  no_req_while_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_o && rsp_ready_o));

  // R7
  sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sticky != 2'b00) && !clr_req) |=> (sticky == $past(sticky)));

  // R11
  reset_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dm_rst_no |-> (!req_valid_o && !rsp_ready_o));

endmodule

bind dmi_bridge dmi_bridge_chk chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_o (req_valid_o),
  .req_ready_i (req_ready_i),
  .rsp_valid_i (rsp_valid_i),
  .rsp_ready_o (rsp_ready_o),
  .dm_rst_no   (dm_rst_no),
  .clr_req     (ctl_upd_i && ctl_wdata_i[16]),
  .sticky      (ctl_rdata_o[11:10])
);

// File: tb/dmi_bridge_tb_top.sv
`timescale 1ns/1ps
module dmi_bridge_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dmi_upd = 1'b0;
  logic        dmi_cap = 1'b0;
  logic [40:0] dmi_scan = '0;
  logic [40:0] cap_word;
  logic        ctl_upd = 1'b0;
  logic [31:0] ctl_wdata = '0;
  logic [31:0] ctl_rdata;
  logic        dm_rst_n;
  logic        req_valid;
  logic        req_ready = 1'b0;
  logic [6:0]  req_addr;
  logic        req_write;
  logic [31:0] req_wdata;
  logic        rsp_valid = 1'b0;
  logic        rsp_ready;
  logic [31:0] rsp_rdata = '0;
  logic        rsp_err = 1'b0;

  int          vectors = 0;
  int          miscompares = 0;
  bit          done = 1'b0;
  logic [31:0] exp_result = '0;
  logic [6:0]  exp_addr = '0;

  always #5 clk = ~clk;

  dmi_bridge dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .dmi_upd_i     (dmi_upd),
    .dmi_cap_i     (dmi_cap),
    .dmi_scan_i    (dmi_scan),
    .dmi_capture_o (cap_word),
    .ctl_upd_i     (ctl_upd),
    .ctl_wdata_i   (ctl_wdata),
    .ctl_rdata_o   (ctl_rdata),
    .dm_rst_no     (dm_rst_n),
    .req_valid_o   (req_valid),
    .req_ready_i   (req_ready),
    .req_addr_o    (req_addr),
    .req_write_o   (req_write),
    .req_wdata_o   (req_wdata),
    .rsp_valid_i   (rsp_valid),
    .rsp_ready_o   (rsp_ready),
    .rsp_rdata_i   (rsp_rdata),
    .rsp_err_i     (rsp_err)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  task automatic clear_sticky();
    @(negedge clk);
    ctl_upd = 1'b1; ctl_wdata = 32'h0001_0000;
    @(negedge clk);
    ctl_upd = 1'b0; ctl_wdata = '0;
    chk("R10", "sticky after clear", 64'(ctl_rdata[11:10]), 64'd0);
    chk("R10", "capture op after clear", 64'(cap_word[1:0]), 64'd0);
  endtask

  task automatic expect_ignored(input string req);
    @(negedge clk);
    dmi_upd = 1'b0; #1;
    chk(req, "ignored update valid c1", 64'(req_valid), 64'd0);
    @(negedge clk); #1;
    chk(req, "ignored update valid c2", 64'(req_valid), 64'd0);
    chk(req, "ignored update rsp_ready", 64'(rsp_ready), 64'd0);
    chk(req, "ignored update addr kept", 64'(cap_word[40:34]), 64'(exp_addr));
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "req_valid", 64'(req_valid), 64'd0);
    chk("R1", "rsp_ready", 64'(rsp_ready), 64'd0);
    chk("R1", "dm reset released", 64'(dm_rst_n), 64'd1);
    chk("R1", "capture word", 64'(cap_word), 64'd0);
    chk("R9", "control word", 64'(ctl_rdata), 64'h0000_1071);
  endtask

  task automatic t_nop(input logic [1:0] op);
    @(negedge clk);
    req_ready = 1'b1;
    dmi_scan = {7'h55, 32'h1111_2222, op};
    dmi_upd = 1'b1;
    expect_ignored("R2");
    chk("R2", "nop status", 64'(cap_word[1:0]), 64'd0);
  endtask

  task automatic t_read(input logic [6:0] addr, input logic [31:0] rd, input logic err);
    @(negedge clk);
    req_ready = 1'b1;
    dmi_scan = {addr, 32'h0, 2'b01};
    dmi_upd = 1'b1;
    @(negedge clk);
    dmi_upd = 1'b0; #1;
    chk("R3", "read valid", 64'(req_valid), 64'd1);
    chk("R3", "read addr", 64'(req_addr), 64'(addr));
    chk("R3", "read write flag", 64'(req_write), 64'd0);
    chk("R6", "in-flight status", 64'(cap_word[1:0]), 64'd3);
    @(negedge clk);
    chk("R3", "valid one cycle", 64'(req_valid), 64'd0);
    chk("R5", "rsp_ready up", 64'(rsp_ready), 64'd1);
    rsp_valid = 1'b1; rsp_rdata = rd; rsp_err = err;
    @(negedge clk);
    rsp_valid = 1'b0; rsp_err = 1'b0; rsp_rdata = '0;
    exp_addr = addr;
    if (!err) exp_result = rd;
    chk("R5", "rsp_ready down", 64'(rsp_ready), 64'd0);
    chk("R5", "capture data", 64'(cap_word[33:2]), 64'(exp_result));
    chk("R2", "capture addr", 64'(cap_word[40:34]), 64'(addr));
    if (err) chk("R8", "failed status", 64'(cap_word[1:0]), 64'd2);
    else     chk("R6", "done status", 64'(cap_word[1:0]), 64'd0);
  endtask

  task automatic t_write(input logic [6:0] addr, input logic [31:0] wd);
    @(negedge clk);
    req_ready = 1'b1;
    dmi_scan = {addr, wd, 2'b10};
    dmi_upd = 1'b1;
    @(negedge clk);
    dmi_upd = 1'b0; #1;
    chk("R3", "write valid", 64'(req_valid), 64'd1);
    chk("R3", "write addr", 64'(req_addr), 64'(addr));
    chk("R3", "write data", 64'(req_wdata), 64'(wd));
    chk("R3", "write flag", 64'(req_write), 64'd1);
    @(negedge clk);
    rsp_valid = 1'b1; rsp_rdata = 32'hFFFF_0000;
    @(negedge clk);
    rsp_valid = 1'b0; rsp_rdata = '0;
    exp_addr = addr;
    chk("R5", "write keeps data", 64'(cap_word[33:2]), 64'(exp_result));
    chk("R6", "write status", 64'(cap_word[1:0]), 64'd0);
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    req_ready = 1'b0;
    dmi_scan = {7'h15, 32'h1234_5678, 2'b10};
    dmi_upd = 1'b1;
    @(negedge clk);
    dmi_upd = 1'b0; #1;
    chk("R4", "held while not ready c1", 64'(req_valid), 64'd0);
    @(negedge clk);
    dmi_scan = {7'h2A, 32'h0, 2'b01};
    dmi_upd = 1'b1; #1;
    chk("R4", "held while not ready c2", 64'(req_valid), 64'd0);
    @(negedge clk);
    dmi_upd = 1'b0;
    chk("R7", "sticky busy", 64'(ctl_rdata[11:10]), 64'd3);
    chk("R7", "capture busy", 64'(cap_word[1:0]), 64'd3);
    req_ready = 1'b1; #1;
    chk("R4", "issued on ready", 64'(req_valid), 64'd1);
    chk("R7", "first addr kept", 64'(req_addr), 64'h15);
    chk("R4", "pending data", 64'(req_wdata), 64'h1234_5678);
    @(negedge clk);
    chk("R4", "single issue", 64'(req_valid), 64'd0);
    rsp_valid = 1'b1;
    @(negedge clk);
    rsp_valid = 1'b0;
    exp_addr = 7'h15;
    chk("R7", "busy stays after response", 64'(cap_word[1:0]), 64'd3);
    chk("R7", "capture addr not second", 64'(cap_word[40:34]), 64'h15);
    dmi_scan = {7'h33, 32'h0, 2'b01};
    dmi_upd = 1'b1;
    expect_ignored("R7");
    clear_sticky();
  endtask

  task automatic t_cap_busy();
    @(negedge clk);
    req_ready = 1'b0;
    dmi_scan = {7'h03, 32'h0, 2'b01};
    dmi_upd = 1'b1;
    @(negedge clk);
    dmi_upd = 1'b0; dmi_cap = 1'b1;
    @(negedge clk);
    dmi_cap = 1'b0;
    chk("R6", "capture makes busy sticky", 64'(ctl_rdata[11:10]), 64'd3);
    req_ready = 1'b1;
    @(negedge clk);
    rsp_valid = 1'b1; rsp_rdata = 32'hA5A5_0001;
    @(negedge clk);
    rsp_valid = 1'b0; rsp_rdata = '0;
    exp_addr = 7'h03;
    exp_result = 32'hA5A5_0001;
    chk("R6", "sticky busy reported", 64'(cap_word[1:0]), 64'd3);
    chk("R5", "read data kept", 64'(cap_word[33:2]), 64'(exp_result));
    clear_sticky();
  endtask

  task automatic t_error();
    t_read(7'h44, 32'h0BAD_0BAD, 1'b1);
    chk("R8", "control sticky fail", 64'(ctl_rdata[11:10]), 64'd2);
    @(negedge clk);
    dmi_scan = {7'h45, 32'h0, 2'b01};
    dmi_upd = 1'b1;
    expect_ignored("R8");
    chk("R8", "fail still reported", 64'(cap_word[1:0]), 64'd2);
    clear_sticky();
  endtask

  task automatic t_dmreset();
    @(negedge clk);
    req_ready = 1'b1;
    dmi_scan = {7'h10, 32'h0, 2'b01};
    dmi_upd = 1'b1;
    @(negedge clk);
    dmi_upd = 1'b0;
    @(negedge clk);
    chk("R11", "waiting before reset", 64'(rsp_ready), 64'd1);
    ctl_upd = 1'b1; ctl_wdata = 32'h0002_0000;
    @(negedge clk);
    ctl_upd = 1'b0; ctl_wdata = '0;
    exp_addr = 7'h10;
    chk("R11", "reset output low", 64'(dm_rst_n), 64'd0);
    chk("R11", "rsp_ready dropped", 64'(rsp_ready), 64'd0);
    chk("R11", "access dropped", 64'(cap_word[1:0]), 64'd0);
    dmi_scan = {7'h11, 32'h0, 2'b01};
    dmi_upd = 1'b1;
    expect_ignored("R11");
    @(negedge clk);
    ctl_upd = 1'b1; ctl_wdata = 32'h0;
    @(negedge clk);
    ctl_upd = 1'b0;
    chk("R11", "reset output released", 64'(dm_rst_n), 64'd1);
    t_read(7'h12, 32'h7777_0012, 1'b0);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_nop(2'b00);
    t_nop(2'b11);
    t_read(7'h01, 32'hDEAD_BEEF, 1'b0);
    t_write(7'h01, 32'hCAFE_F00D);
    t_read(7'h7F, 32'h8000_0001, 1'b0);
    t_backpressure();
    t_cap_busy();
    t_error();
    t_dmreset();
    done = 1'b1;
    summary();
    $finish;
  end

endmodule